// File: doc/BRIEF.md
# Multi-PHY Receive Cell Port

This block sits at the receive edge of a multi-port cell PHY. A line-side source writes 53-byte cells one byte per cycle, tagging each cell with a local port number on its first byte. The block keeps one small cell queue for every local port and hands the stored cells, byte by byte, to a cell-layer device over a UTOPIA Level 2 style interface. The device polls with a 5-bit receive address, sees a cell-available flag for that address, and pulls a cell by holding an active-low enable. While the enable is high, output pauses.

Each queue holds four whole cells. A cell that arrives for a full queue is thrown away as a whole, and a sticky overflow flag for that port is raised. Software clears these flags by writing zeros to them. A per-port enable mask decides which flags drive the interrupt line.

Top module: `mphy_rx_cell_port`

## Requirements
- R1: Each cell leaves the port as exactly 53 consecutive valid bytes, and `rx_soc` is high only with the first byte. Output is registered, so a byte appears one cycle after the clock edge that took it.
- R2: Each port's queue holds up to four whole cells and delivers them in arrival order, byte for byte.
- R3: A new cell transfer starts only at a cell boundary. It starts on an edge where `rx_enb_n` is low, `rx_addr` is below the number of local ports (16), and that port holds at least one complete cell. The address is not looked at again until that cell ends. An address of 16 to 31, or the address of an empty port, starts nothing.
- R4: During a transfer, every edge with `rx_enb_n` high yields no valid byte. The next edge with the enable low yields the following byte of the same cell.
- R5: `rx_clav` is high exactly when `rx_addr` names a local port whose queue holds at least one completely written cell. It follows the address combinationally.
- R6: A byte with `in_soc` high starts a cell for `in_port`. If that queue already holds four cells, the whole cell is discarded. A byte with `in_soc` low that is not inside an accepted cell is ignored. A new start byte abandons any partly written cell.
- R7: A discarded cell sets bit `in_port` of `ovf_status`, and the bit stays set. When `stat_wr` is high, each bit whose `stat_wdata` bit is 0 is cleared. A set in the same cycle wins over the clear.
- R8: `irq` is high exactly when some bit is set in both `ovf_status` and `irq_en`.
- R9: After reset, `rx_valid`, `rx_soc`, `rx_clav`, `ovf_status` and `irq` are all 0, and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Line-side byte is present |
| in_soc | input | 1 | Line-side byte is the first of a cell |
| in_port | input | 4 | Local port of the cell, sampled with `in_soc` |
| in_data | input | 8 | Line-side byte |
| rx_addr | input | 5 | Poll and select address from the cell-layer device |
| rx_enb_n | input | 1 | Active-low read enable |
| rx_data | output | 8 | Output byte |
| rx_soc | output | 1 | Output byte is the first of a cell |
| rx_valid | output | 1 | `rx_data` carries a byte this cycle |
| rx_clav | output | 1 | Addressed port holds a complete cell |
| stat_wr | input | 1 | Write strobe for the overflow flags |
| stat_wdata | input | 16 | Write data; a 0 bit clears that flag |
| irq_en | input | 16 | Per-port interrupt enable |
| ovf_status | output | 16 | Sticky per-port overflow flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong cell count or slot pointer in one port's queue shows up at once. Either `rx_clav` goes wrong for that address on the same cycle, or the first byte of the next cell from that port differs from the bench model one cycle after the enabling edge. A wrong byte index inside the read engine shows as `rx_soc` off its 53-byte stride, or as a wrong byte, within one transfer. A flag that fails to stick or to clear shows on `ovf_status` and `irq` on the cycle after the drop or the write.

// File: rtl/cellport_pkg.sv
package cellport_pkg;
   localparam int CELL_LEN = 53;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cq_store.sv
module cq_store #(
   parameter int DATA_W    = 8,
   parameter int NUM_PORTS = 16,
   parameter int DEPTH     = 4,
   parameter int CELL_LEN  = 53,
   localparam int PW       = $clog2(NUM_PORTS),
   localparam int SW       = $clog2(DEPTH),
   localparam int IW       = $clog2(CELL_LEN)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     wport,
   input  logic [SW-1:0]     wslot,
   input  logic [IW-1:0]     widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PW-1:0]     rport,
   input  logic [SW-1:0]     rslot,
   input  logic [IW-1:0]     ridx,
   output logic [DATA_W-1:0] rdata
);
   localparam int ENTRIES = NUM_PORTS * DEPTH * CELL_LEN;
   localparam int AW      = $clog2(ENTRIES);

   logic [DATA_W-1:0] mem [ENTRIES];
   logic [AW-1:0]     wa, ra;

   always_comb begin
      wa = AW'((int'(wport) * DEPTH + int'(wslot)) * CELL_LEN + int'(widx));
      ra = AW'((int'(rport) * DEPTH + int'(rslot)) * CELL_LEN + int'(ridx));
   end

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wdata;
   end

   assign rdata = mem[ra];
endmodule

// File: rtl/cq_occupancy.sv
module cq_occupancy #(
   parameter int NUM_PORTS = 16,
   parameter int DEPTH     = 4,
   localparam int PW       = $clog2(NUM_PORTS),
   localparam int SW       = $clog2(DEPTH),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          push,
   input  logic [PW-1:0]                 push_port,
   input  logic                          pop,
   input  logic [PW-1:0]                 pop_port,
   output logic [NUM_PORTS-1:0][SW-1:0]  wr_slot,
   output logic [NUM_PORTS-1:0][SW-1:0]  rd_slot,
   output logic [NUM_PORTS-1:0][CW-1:0]  cells
);
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      logic          push_i, pop_i;
      logic [SW-1:0] wr_q, rd_q;
      logic [CW-1:0] cnt_q;

      assign push_i = push && (push_port == PW'(i));
      assign pop_i  = pop  && (pop_port  == PW'(i));

      always_ff @(posedge clk) begin
         if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push_i) wr_q <= wr_q + 1'b1;
            if (pop_i)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
         end
      end

      assign wr_slot[i] = wr_q;
      assign rd_slot[i] = rd_q;
      assign cells[i]   = cnt_q;

      // R2: a queue never holds more than DEPTH cells
      p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
         cnt_q <= CW'(DEPTH));
      // R2: the reader never retires a cell from an empty queue
      p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (rst)
         pop_i |-> (cnt_q != '0));
      // R6: a cell is only committed into a queue with room
      p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
         push_i |-> (cnt_q != CW'(DEPTH)));
   end
endmodule

// File: rtl/ovf_flags.sv
module ovf_flags #(
   parameter int NUM_PORTS = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_PORTS-1:0] set_vec,
   input  logic                 wr,
   input  logic [NUM_PORTS-1:0] wdata,
   input  logic [NUM_PORTS-1:0] en,
   output logic [NUM_PORTS-1:0] flags,
   output logic                 irq
);
   logic [NUM_PORTS-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (rst)     flags_q <= '0;
      else if (wr) flags_q <= (flags_q & wdata) | set_vec;
      else         flags_q <= flags_q | set_vec;
   end

   assign flags = flags_q;
   assign irq   = |(flags_q & en);

   // R7: without a write no flag ever falls
   p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      !wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
   // R7: a drop is always visible on the next cycle
   p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/mphy_rx_cell_port.sv
module mphy_rx_cell_port
   import cellport_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_PORTS = 16,
   parameter int ADDR_W    = 5,
   parameter int DEPTH     = 4,
   localparam int PW       = $clog2(NUM_PORTS),
   localparam int SW       = $clog2(DEPTH),
   localparam int IW       = $clog2(CELL_LEN),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic                 in_soc,
   input  logic [PW-1:0]        in_port,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [ADDR_W-1:0]    rx_addr,
   input  logic                 rx_enb_n,
   output logic [DATA_W-1:0]    rx_data,
   output logic                 rx_soc,
   output logic                 rx_valid,
   output logic                 rx_clav,
   input  logic                 stat_wr,
   input  logic [NUM_PORTS-1:0] stat_wdata,
   input  logic [NUM_PORTS-1:0] irq_en,
   output logic [NUM_PORTS-1:0] ovf_status,
   output logic                 irq
);
   if (!is_pow2(NUM_PORTS) || NUM_PORTS > (1 << ADDR_W) - 1) begin : g_bad_ports
      $error("NUM_PORTS must be a power of two below 2**ADDR_W");
   end
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   localparam logic [IW-1:0] LAST_IDX = IW'(CELL_LEN - 1);

   logic [NUM_PORTS-1:0][SW-1:0] wr_slot, rd_slot;
   logic [NUM_PORTS-1:0][CW-1:0] cells;

   // line-side writer
   logic              w_act;
   logic [PW-1:0]     w_port;
   logic [SW-1:0]     w_slot;
   logic [IW-1:0]     w_idx;
   logic              start, accept, wr_en, push;
   logic [PW-1:0]     st_port;
   logic [SW-1:0]     st_slot;
   logic [IW-1:0]     st_idx;
   logic [NUM_PORTS-1:0] set_vec;

   always_comb begin
      start   = in_valid && in_soc;
      accept  = start && (cells[in_port] != CW'(DEPTH));
      wr_en   = accept || (in_valid && !in_soc && w_act);
      st_port = accept ? in_port          : w_port;
      st_slot = accept ? wr_slot[in_port] : w_slot;
      st_idx  = accept ? '0               : w_idx;
      push    = wr_en && !accept && (w_idx == LAST_IDX);
      set_vec = '0;
      if (start && !accept) set_vec[in_port] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         w_act  <= 1'b0;
         w_port <= '0;
         w_slot <= '0;
         w_idx  <= '0;
      end else if (start) begin
         w_act  <= accept;
         w_port <= in_port;
         w_slot <= wr_slot[in_port];
         w_idx  <= IW'(1);
      end else if (wr_en) begin
         w_idx <= w_idx + 1'b1;
         if (push) w_act <= 1'b0;
      end
   end

   // cell-layer reader
   logic              r_busy;
   logic [PW-1:0]     r_port;
   logic [IW-1:0]     r_idx;
   logic              addr_ok, go, pop;
   logic [PW-1:0]     sel_port, cur_port;
   logic [DATA_W-1:0] rd_byte;

   always_comb begin
      addr_ok  = rx_addr < ADDR_W'(NUM_PORTS);
      sel_port = rx_addr[PW-1:0];
      rx_clav  = addr_ok && (cells[sel_port] != '0);
      go       = !rx_enb_n && (r_busy || rx_clav);
      cur_port = r_busy ? r_port : sel_port;
      pop      = go && (r_idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         r_busy   <= 1'b0;
         r_port   <= '0;
         r_idx    <= '0;
         rx_valid <= 1'b0;
         rx_soc   <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= go;
         rx_soc   <= go && (r_idx == '0);
         if (go) begin
            rx_data <= rd_byte;
            r_port  <= cur_port;
            r_busy  <= !pop;
            r_idx   <= pop ? '0 : r_idx + 1'b1;
         end
      end
   end

   // R4: a high enable mid-cell yields no byte on the next cycle
   p_stall_r4: assert property (@(posedge clk) disable iff (rst)
      (r_busy && rx_enb_n) |=> !rx_valid);
   // R1: a start-of-cell byte only follows an idle reader
   p_soc_start_r1: assert property (@(posedge clk) disable iff (rst)
      rx_soc |-> (rx_valid && !$past(r_busy)));

   cq_store #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .CELL_LEN(CELL_LEN)) u_store (
      .clk   (clk),
      .we    (wr_en),
      .wport (st_port),
      .wslot (st_slot),
      .widx  (st_idx),
      .wdata (in_data),
      .rport (cur_port),
      .rslot (rd_slot[cur_port]),
      .ridx  (r_idx),
      .rdata (rd_byte)
   );

   cq_occupancy #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_occ (
      .clk       (clk),
      .rst       (rst),
      .push      (push),
      .push_port (w_port),
      .pop       (pop),
      .pop_port  (cur_port),
      .wr_slot   (wr_slot),
      .rd_slot   (rd_slot),
      .cells     (cells)
   );

   ovf_flags #(.NUM_PORTS(NUM_PORTS)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec),
      .wr      (stat_wr),
      .wdata   (stat_wdata),
      .en      (irq_en),
      .flags   (ovf_status),
      .irq     (irq)
   );
endmodule

// File: tb/tb_mphy_rx_cell_port.sv
`timescale 1ns/1ps
module tb_mphy_rx_cell_port;
   localparam int NP = 16;
   localparam int CL = 53;
   localparam int QD = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0, in_soc = 1'b0;
   logic [3:0]  in_port = '0;
   logic [7:0]  in_data = '0;
   logic [4:0]  rx_addr = '0;
   logic        rx_enb_n = 1'b1;
   logic [7:0]  rx_data;
   logic        rx_soc, rx_valid, rx_clav;
   logic        stat_wr = 1'b0;
   logic [15:0] stat_wdata = '0;
   logic [15:0] irq_en = '0;
   logic [15:0] ovf_status;
   logic        irq;

   always #2 clk = ~clk;

   mphy_rx_cell_port dut (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_soc(in_soc), .in_port(in_port), .in_data(in_data),
      .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
      .rx_data(rx_data), .rx_soc(rx_soc), .rx_valid(rx_valid), .rx_clav(rx_clav),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
      .ovf_status(ovf_status), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [7:0] mq [NP][$];
   logic [7:0] pend [$];
   bit         m_busy, m_wact, ev, es;
   int         m_cur, m_idx, m_wport;
   logic [7:0] ed;
   logic [15:0] m_ovf;
   int         drained [NP];

   always @(posedge clk) begin
      int cnt_s [NP];
      logic [15:0] setv;
      if (rst) begin
         for (int p = 0; p < NP; p++) begin mq[p].delete(); drained[p] = 0; end
         pend.delete();
         m_busy = 0; m_wact = 0; ev = 0; es = 0; m_cur = 0; m_idx = 0; m_ovf = '0;
      end else begin
         for (int p = 0; p < NP; p++) cnt_s[p] = mq[p].size() / CL;
         setv = '0;
         if (!rx_enb_n && (m_busy || (rx_addr < NP && cnt_s[rx_addr] > 0))) begin
            if (!m_busy) m_cur = int'(rx_addr);
            ed = mq[m_cur][m_idx];
            es = (m_idx == 0);
            ev = 1;
            m_busy = 1;
            m_idx++;
            if (m_idx == CL) begin
               repeat (CL) void'(mq[m_cur].pop_front());
               drained[m_cur]++;
               m_busy = 0;
               m_idx = 0;
            end
         end else begin
            ev = 0; es = 0;
         end
         if (in_valid && in_soc) begin
            if (cnt_s[in_port] >= QD) begin
               setv[in_port] = 1'b1;
               m_wact = 0;
            end else begin
               m_wact = 1;
               m_wport = int'(in_port);
               pend.delete();
               pend.push_back(in_data);
            end
         end else if (in_valid && m_wact) begin
            pend.push_back(in_data);
            if (pend.size() == CL) begin
               foreach (pend[k]) mq[m_wport].push_back(pend[k]);
               pend.delete();
               m_wact = 0;
            end
         end
         if (stat_wr) m_ovf = m_ovf & stat_wdata;
         m_ovf = m_ovf | setv;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         bit eclav;
         eclav = (rx_addr < NP) && (mq[rx_addr].size() >= CL);
         chk(rx_valid == ev, "R4", "rx_valid", rx_valid, ev);
         if (ev) chk(rx_data == ed, "R2", "rx_data", rx_data, ed);
         chk(rx_soc == es, "R1", "rx_soc", rx_soc, es);
         chk(rx_clav == eclav, "R5", "rx_clav", rx_clav, eclav);
         chk(ovf_status == m_ovf, "R7", "ovf_status", ovf_status, m_ovf);
         chk(irq == |(m_ovf & irq_en), "R8", "irq", irq, |(m_ovf & irq_en));
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send_cell(input int port, input int seed, input bit gaps, input int nbytes);
      for (int i = 0; i < nbytes; i++) begin
         in_valid = 1'b1;
         in_soc   = (i == 0);
         in_port  = 4'(port);
         in_data  = 8'(seed + i);
         tick();
         if (gaps && (i % 7 == 3)) begin
            in_valid = 1'b0;
            tick();
         end
      end
      in_valid = 1'b0;
      in_soc   = 1'b0;
   endtask

   task automatic pull(input int addr, input int cycles);
      rx_addr  = 5'(addr);
      rx_enb_n = 1'b0;
      repeat (cycles) tick();
      rx_enb_n = 1'b1;
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      @(negedge clk);
      // R9: reset state
      chk(rx_valid == 0 && rx_soc == 0, "R9", "rx_valid/soc after reset", rx_valid, 0);
      chk(rx_clav == 0, "R9", "rx_clav after reset", rx_clav, 0);
      chk(ovf_status == 0 && irq == 0, "R9", "status after reset", ovf_status, 0);
      tick();

      irq_en = 16'h0020;
      send_cell(3, 8'h10, 1'b0, CL);
      send_cell(3, 8'h40, 1'b1, CL);
      send_cell(0, 8'h80, 1'b0, CL);
      pull(3, 120);                          // R1 R2: two back-to-back cells
      rx_addr = 5'd0;
      for (int k = 0; k < 100; k++) begin    // R4: stalls mid-cell
         rx_enb_n = (k % 3 == 1);
         tick();
      end
      rx_enb_n = 1'b1;

      for (int c = 0; c < 5; c++) send_cell(5, 8'h20 * c, 1'b0, CL);
      tick();
      @(negedge clk);
      chk(ovf_status[5] == 1'b1, "R7", "flag after drop", ovf_status[5], 1);
      chk(irq == 1'b1, "R8", "irq with enable", irq, 1);
      tick();

      stat_wr = 1'b1; stat_wdata = 16'hFFFF; tick();
      stat_wr = 1'b0;
      @(negedge clk);
      chk(ovf_status[5] == 1'b1, "R7", "flag kept by ones write", ovf_status[5], 1);
      tick();
      stat_wr = 1'b1; stat_wdata = ~16'h0020; tick();
      stat_wr = 1'b0;
      @(negedge clk);
      chk(ovf_status[5] == 1'b0, "R7", "flag cleared by zero write", ovf_status[5], 0);
      tick();

      irq_en = 16'h0000;
      send_cell(5, 8'hA0, 1'b0, CL);         // R6: dropped again
      tick();
      @(negedge clk);
      chk(irq == 1'b0, "R8", "irq masked", irq, 0);
      tick();
      irq_en = 16'hFFFF;

      pull(31, 10);                          // R3: address beyond local ports
      @(negedge clk);
      chk(rx_valid == 1'b0, "R3", "no transfer from address 31", rx_valid, 0);
      tick();
      pull(9, 10);                           // R3: empty port
      @(negedge clk);
      chk(rx_valid == 1'b0, "R3", "no transfer from empty port", rx_valid, 0);
      tick();

      pull(5, CL * 5 + 5);
      chk(drained[5] == 4, "R6", "cells kept from full queue", drained[5], 4);

      for (int k = 0; k < 10; k++) begin     // R6: stray bytes outside a cell
         in_valid = 1'b1; in_soc = 1'b0; in_port = 4'd7; in_data = 8'(k);
         tick();
      end
      in_valid = 1'b0;
      rx_addr = 5'd7;
      @(negedge clk);
      chk(rx_clav == 1'b0, "R6", "stray bytes make no cell", rx_clav, 0);
      tick();

      fork
         begin
            send_cell(7, 8'h33, 1'b1, CL);
            send_cell(7, 8'h66, 1'b0, CL);
         end
         begin
            repeat (60) tick();
            pull(7, 150);
         end
      join

      send_cell(2, 8'h11, 1'b0, 20);         // R6: abandoned partial cell
      send_cell(2, 8'h55, 1'b0, CL);
      pull(2, 60);
      chk(drained[2] == 1, "R6", "only the restarted cell kept", drained[2], 1);
      chk(drained[7] == 2, "R2", "cells read while writing", drained[7], 2);
      chk(drained[3] == 2 && drained[0] == 1, "R1", "cells drained", drained[3], 2);

      repeat (4) tick();
      finish_up();
   end
endmodule